// File: doc/BRIEF.md
# Smart Card Serial Status Flags

This block keeps the status flags of an asynchronous serial channel that runs in smart card mode. The transmit and receive datapaths send it one-cycle event strobes: the transmit buffer was handed to the shift register, a character was received, the receiver sampled a low error signal, and the parity bit of a transmitted character has ended. The block turns these strobes into six sticky flags. It presents the flags as one status byte and raises transmit, receive and error interrupt requests.

Software clears a flag by reading the status byte while the flag is 1 and then writing 0 to that flag's bit. A transfer engine can also clear a flag through two dedicated strobes, one for a write to the transmit buffer and one for a read of the receive buffer. The transmit-done flag is the one timed flag. It rises a fixed number of half bit-times (half etu) after a character ends, and that number depends on the guard/block mode. It rises only if no error signal arrived in the meantime.

Top module: `sc_status_flags`

## Requirements
- R1: After reset the status byte reads 8'h21. Bit 0 is tx_empty, bit 1 rx_full, bit 2 overrun, bit 3 err_sig, bit 4 par_err and bit 5 tx_done, and bits 7:6 read 0. After reset only tx_empty and tx_done are 1.
- R2: Software clears a clearable flag (bits 4:0) by writing 0 to its bit. The write works only if a status read since the previous write returned 1 in that bit. Writing 1 has no effect, and every write disarms all bits.
- R3: tx_empty is set in every cycle in which transmit-enable is 0, and on a buffer-to-shifter transfer strobe. It is cleared by the software sequence or by the transfer-engine write strobe.
- R4: rx_full is set when a reception ends with correct parity while rx_full is 0. It is cleared by the software sequence or by the transfer-engine read strobe.
- R5: A reception that ends while rx_full is 1 sets overrun. rx_full stays 1.
- R6: A reception whose data ones plus the parity bit give an odd total in even mode (odd_parity_i=0), or an even total in odd mode, sets par_err and leaves rx_full unchanged.
- R7: A sampled low error signal sets err_sig. err_sig is cleared by the software sequence or by standby. Dropping transmit-enable does not change it.
- R8: tx_done is read-only, so writing 0 to bit 5 has no effect. tx_done clears whenever a tx_empty clear request takes effect.
- R9: tx_done is set in every cycle in which transmit-enable is 0 and err_sig is 0.
- R10: After a character-end strobe, tx_done is set on the 5th half-etu tick when gsm_mode_i=0 and blk_mode_i=0, on the 3rd when gsm_mode_i=0 and blk_mode_i=1, and on the 2nd when gsm_mode_i=1. This happens only if tx_empty is 1 and err_sig is 0 at that tick. A low error signal or standby cancels the wait.
- R11: When a hardware set and a clear land on a flag in the same cycle, the set wins.
- R12: tx_irq_o = tx_empty AND tx_irq_en_i. rx_irq_o = rx_full AND rx_irq_en_i. err_irq_o = overrun OR err_sig OR par_err.
- R13: Standby clears err_sig, sets tx_done and cancels a pending tx_done delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby / module stop request |
| tx_en_i | input | 1 | Transmit enable |
| gsm_mode_i | input | 1 | Short guard time mode |
| blk_mode_i | input | 1 | Block transfer mode |
| half_etu_i | input | 1 | Half bit-time tick |
| tx_xfer_i | input | 1 | Transmit buffer moved to shifter |
| tx_char_end_i | input | 1 | Parity bit of transmitted character ended |
| rx_done_i | input | 1 | Reception complete |
| rx_data_i | input | DATA_W | Received data |
| rx_par_i | input | 1 | Received parity bit |
| odd_parity_i | input | 1 | 1 selects odd parity |
| err_low_i | input | 1 | Low level of error signal sampled |
| dma_tx_wr_i | input | 1 | Transfer engine wrote transmit buffer |
| dma_rx_rd_i | input | 1 | Transfer engine read receive buffer |
| st_rd_i | input | 1 | Status byte read strobe |
| st_wr_i | input | 1 | Status byte write strobe |
| st_wdata_i | input | 5 | Write data for bits 4:0 |
| st_rdata_o | output | 8 | Status byte |
| tx_irq_en_i | input | 1 | Transmit interrupt enable |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The hardest situation to reach is the end of the tx_done delay. At the exact tick that ends it, tx_empty must still be 1 and err_sig 0, and an error-signal pulse or a restart may have landed inside the window. Directed sequences build this case: a clear of tx_empty, then a transfer, then a character end, then counted half-etu ticks, once with an error pulse placed between the ticks. A long random phase then runs in each of the four mode combinations, with sparse character ends and dense ticks so that many waits complete. It also puts set and clear strobes in the same cycles. A behavioural model compares every output on every cycle.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;
  localparam int unsigned FLAG_N = 6;
  localparam int unsigned CLR_N  = 5;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned B_TX_EMPTY = 0;
  localparam int unsigned B_RX_FULL  = 1;
  localparam int unsigned B_OVERRUN  = 2;
  localparam int unsigned B_ERR_SIG  = 3;
  localparam int unsigned B_PAR_ERR  = 4;
  localparam int unsigned B_TX_DONE  = 5;

  typedef struct packed {
    logic tx_done;
    logic par_err;
    logic err_sig;
    logic overrun;
    logic rx_full;
    logic tx_empty;
  } flags_t;
endpackage

// File: rtl/sc_clear_gate.sv
module sc_clear_gate #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] clr_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic armed_q;

    // arm on a read that saw 1; any write disarms
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  armed_q <= 1'b0;
      else if (wr_i)                armed_q <= 1'b0;
      else if (rd_i && flags_i[i])  armed_q <= 1'b1;
    end

    assign clr_o[i] = wr_i & ~wdata_i[i] & armed_q;

    AST_WR_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> !clr_o[i]); // R2
  end
endmodule

// File: rtl/sc_tend_timer.sv
module sc_tend_timer #(
  parameter int unsigned HALF_STD = 5,
  parameter int unsigned HALF_BLK = 3,
  parameter int unsigned HALF_GSM = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic cancel_i,
  input  logic gsm_i,
  input  logic blk_i,
  output logic expire_o
);
  localparam int unsigned HALF_AB  = (HALF_STD > HALF_BLK) ? HALF_STD : HALF_BLK;
  localparam int unsigned HALF_MAX = (HALF_AB > HALF_GSM) ? HALF_AB : HALF_GSM;
  localparam int unsigned CNT_W    = $clog2(HALF_MAX + 1);

  logic             on_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] target;

  always_comb begin
    if (gsm_i)      target = CNT_W'(HALF_GSM);
    else if (blk_i) target = CNT_W'(HALF_BLK);
    else            target = CNT_W'(HALF_STD);
  end

  assign expire_o = on_q & tick_i & (rem_q == CNT_W'(1)) & ~cancel_i & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      rem_q <= '0;
    end else if (cancel_i) begin
      on_q  <= 1'b0;
    end else if (start_i) begin
      on_q  <= 1'b1;
      rem_q <= target;
    end else if (on_q && tick_i) begin
      rem_q <= rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) on_q <= 1'b0;
    end
  end

  AST_REM_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q |-> (rem_q != '0)); // R10
  AST_EXPIRE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !on_q); // R10
  AST_CANCEL_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !on_q); // R13
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              odd_i,
  input  logic              dma_rd_i,
  input  logic              clr_full_i,
  input  logic              clr_ovr_i,
  input  logic              clr_par_i,
  output logic              rx_full_o,
  output logic              overrun_o,
  output logic              par_err_o
);
  logic par_ok;
  logic set_full, set_ovr, set_par;

  assign par_ok   = ((^data_i) ^ par_i) == odd_i;
  assign set_full = rx_done_i & par_ok & ~rx_full_o;
  assign set_ovr  = rx_done_i & rx_full_o;
  assign set_par  = rx_done_i & ~par_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_o <= 1'b0;
      overrun_o <= 1'b0;
      par_err_o <= 1'b0;
    end else begin
      if (set_full)                    rx_full_o <= 1'b1;
      else if (clr_full_i || dma_rd_i) rx_full_o <= 1'b0;
      if (set_ovr)                     overrun_o <= 1'b1;
      else if (clr_ovr_i)              overrun_o <= 1'b0;
      if (set_par)                     par_err_o <= 1'b1;
      else if (clr_par_i)              par_err_o <= 1'b0;
    end
  end

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_full_o)); // R5
  AST_BAD_PAR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && (((^data_i) ^ par_i) != odd_i)) |=> par_err_o); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !clr_full_i && !dma_rd_i) |=> rx_full_o); // R4
endmodule

// File: rtl/sc_status_flags.sv
module sc_status_flags
  import sc_status_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_STD = 5,
  parameter int unsigned HALF_BLK = 3,
  parameter int unsigned HALF_GSM = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              tx_en_i,
  input  logic              gsm_mode_i,
  input  logic              blk_mode_i,
  input  logic              half_etu_i,
  input  logic              tx_xfer_i,
  input  logic              tx_char_end_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              odd_parity_i,
  input  logic              err_low_i,
  input  logic              dma_tx_wr_i,
  input  logic              dma_rx_rd_i,
  input  logic              st_rd_i,
  input  logic              st_wr_i,
  input  logic [CLR_N-1:0]  st_wdata_i,
  output logic [STAT_W-1:0] st_rdata_o,
  input  logic              tx_irq_en_i,
  input  logic              rx_irq_en_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  flags_t            fl;
  logic [FLAG_N-1:0] fl_vec;
  logic [CLR_N-1:0]  sw_clr;

  logic tx_empty_q, err_sig_q, tx_done_q;
  logic rx_full, overrun, par_err;
  logic txe_set, txe_clr_req, txe_clr_eff;
  logic expire, tend_set;

  assign fl.tx_empty = tx_empty_q;
  assign fl.rx_full  = rx_full;
  assign fl.overrun  = overrun;
  assign fl.err_sig  = err_sig_q;
  assign fl.par_err  = par_err;
  assign fl.tx_done  = tx_done_q;
  assign fl_vec      = fl;

  sc_clear_gate #(.N(CLR_N)) u_clr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (st_rd_i),
    .wr_i    (st_wr_i),
    .wdata_i (st_wdata_i),
    .flags_i (fl_vec[CLR_N-1:0]),
    .clr_o   (sw_clr)
  );

  sc_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_done_i  (rx_done_i),
    .data_i     (rx_data_i),
    .par_i      (rx_par_i),
    .odd_i      (odd_parity_i),
    .dma_rd_i   (dma_rx_rd_i),
    .clr_full_i (sw_clr[B_RX_FULL]),
    .clr_ovr_i  (sw_clr[B_OVERRUN]),
    .clr_par_i  (sw_clr[B_PAR_ERR]),
    .rx_full_o  (rx_full),
    .overrun_o  (overrun),
    .par_err_o  (par_err)
  );

  sc_tend_timer #(
    .HALF_STD (HALF_STD),
    .HALF_BLK (HALF_BLK),
    .HALF_GSM (HALF_GSM)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tx_char_end_i),
    .tick_i   (half_etu_i),
    .cancel_i (standby_i | err_low_i),
    .gsm_i    (gsm_mode_i),
    .blk_i    (blk_mode_i),
    .expire_o (expire)
  );

  // transmit buffer empty
  assign txe_set     = ~tx_en_i | tx_xfer_i;
  assign txe_clr_req = sw_clr[B_TX_EMPTY] | dma_tx_wr_i;
  assign txe_clr_eff = txe_clr_req & ~txe_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tx_empty_q <= 1'b1;
    else if (txe_set)     tx_empty_q <= 1'b1;
    else if (txe_clr_req) tx_empty_q <= 1'b0;
  end

  // error signal status; standby dominates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  err_sig_q <= 1'b0;
    else if (standby_i)           err_sig_q <= 1'b0;
    else if (err_low_i)           err_sig_q <= 1'b1;
    else if (sw_clr[B_ERR_SIG])   err_sig_q <= 1'b0;
  end

  // transmit end
  assign tend_set = standby_i
                  | (~tx_en_i & ~err_sig_q)
                  | (expire & tx_empty_q & ~err_sig_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tx_done_q <= 1'b1;
    else if (tend_set)    tx_done_q <= 1'b1;
    else if (txe_clr_eff) tx_done_q <= 1'b0;
  end

  assign st_rdata_o = {{(STAT_W-FLAG_N){1'b0}}, fl_vec};
  assign tx_irq_o   = tx_empty_q & tx_irq_en_i;
  assign rx_irq_o   = rx_full & rx_irq_en_i;
  assign err_irq_o  = overrun | err_sig_q | par_err;

  AST_TXE_TX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> tx_empty_q); // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_xfer_i |=> tx_empty_q); // R11
  AST_TEND_FOLLOWS_TXE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tx_empty_q) && !$past(tend_set)) |-> !tx_done_q); // R8
  AST_TEND_RISE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_q) |-> ($past(standby_i) || !$past(err_sig_q))); // R10
  AST_ERS_FALL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_sig_q) |-> $past(standby_i || st_wr_i)); // R7
endmodule

// File: tb/sc_status_flags_tb_top.sv
module sc_status_flags_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic standby = 0, tx_en = 0, gsm = 0, blk = 0, htick = 0, xfer = 0, char_end = 0;
  logic rx_done = 0, rx_par = 0, odd = 0, err_low = 0, dma_wr = 0, dma_rd = 0;
  logic st_rd = 0, st_wr = 0, tie = 0, rie = 0;
  logic [7:0] rx_data = 8'h00;
  logic [4:0] st_wdata = 5'h1f;
  logic [7:0] st_rdata;
  logic txi, rxi, eri;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sc_status_flags dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .standby_i(standby), .tx_en_i(tx_en),
    .gsm_mode_i(gsm), .blk_mode_i(blk), .half_etu_i(htick), .tx_xfer_i(xfer),
    .tx_char_end_i(char_end), .rx_done_i(rx_done), .rx_data_i(rx_data),
    .rx_par_i(rx_par), .odd_parity_i(odd), .err_low_i(err_low),
    .dma_tx_wr_i(dma_wr), .dma_rx_rd_i(dma_rd), .st_rd_i(st_rd), .st_wr_i(st_wr),
    .st_wdata_i(st_wdata), .st_rdata_o(st_rdata), .tx_irq_en_i(tie),
    .rx_irq_en_i(rie), .tx_irq_o(txi), .rx_irq_o(rxi), .err_irq_o(eri)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: m_f bit0 tx_empty .. bit5 tx_done
  bit [5:0] m_f;
  bit [4:0] m_arm;
  bit       t_on;
  int       t_rem;

  always @(posedge clk or negedge rst_ni) begin
    bit [5:0] o;
    bit [4:0] clr;
    bit pok, expd, tset, tdre_set, tdre_req;
    if (!rst_ni) begin
      m_f = 6'b100001; m_arm = '0; t_on = 0; t_rem = 0;
    end else begin
      o = m_f;
      clr = st_wr ? (~st_wdata & m_arm) : 5'b0;
      if (st_wr) m_arm = '0;
      else if (st_rd) m_arm = m_arm | o[4:0];
      expd = 0;
      if (standby || err_low) t_on = 0;
      else if (char_end) begin
        t_on = 1;
        t_rem = gsm ? 2 : (blk ? 3 : 5);
      end else if (t_on && htick) begin
        t_rem = t_rem - 1;
        if (t_rem == 0) begin t_on = 0; expd = 1; end
      end
      pok = ((^rx_data) ^ rx_par) == odd;
      tdre_set = !tx_en || xfer;
      tdre_req = clr[0] || dma_wr;
      m_f[0] = tdre_set ? 1'b1 : (tdre_req ? 1'b0 : o[0]);
      m_f[1] = (rx_done && pok && !o[1]) ? 1'b1 : ((clr[1] || dma_rd) ? 1'b0 : o[1]);
      m_f[2] = (rx_done && o[1]) ? 1'b1 : (clr[2] ? 1'b0 : o[2]);
      m_f[3] = standby ? 1'b0 : (err_low ? 1'b1 : (clr[3] ? 1'b0 : o[3]));
      m_f[4] = (rx_done && !pok) ? 1'b1 : (clr[4] ? 1'b0 : o[4]);
      tset = standby || (!tx_en && !o[3]) || (expd && o[0] && !o[3]);
      m_f[5] = tset ? 1'b1 : ((tdre_req && !tdre_set) ? 1'b0 : o[5]);
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always begin
    @(posedge clk);
    #5;
    if (rst_ni && !done) begin
      chk("R3",  "tx_empty", st_rdata[0], m_f[0]);
      chk("R4",  "rx_full",  st_rdata[1], m_f[1]);
      chk("R5",  "overrun",  st_rdata[2], m_f[2]);
      chk("R7",  "err_sig",  st_rdata[3], m_f[3]);
      chk("R6",  "par_err",  st_rdata[4], m_f[4]);
      chk("R10", "tx_done",  st_rdata[5], m_f[5]);
      chk("R1",  "rsvd",     st_rdata[7:6], 0);
      chk("R12", "tx_irq",   txi, m_f[0] & tie);
      chk("R12", "rx_irq",   rxi, m_f[1] & rie);
      chk("R12", "err_irq",  eri, m_f[2] | m_f[3] | m_f[4]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_clear(input logic [4:0] bits);
    st_rd = 1; cyc(); st_rd = 0;
    st_wr = 1; st_wdata = ~bits; cyc(); st_wr = 0; st_wdata = 5'h1f;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      htick = 1; cyc(); htick = 0; cyc();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    cyc();
    chk("R1", "reset byte", st_rdata, 8'h21);

    tx_en = 1; cyc();
    st_wr = 1; st_wdata = 5'h00; cyc(); st_wr = 0; st_wdata = 5'h1f;
    chk("R2", "write w/o read", st_rdata[0], 1);
    st_rd = 1; cyc(); st_rd = 0;
    st_wr = 1; st_wdata = 5'h1f; cyc();
    chk("R2", "write one", st_rdata[0], 1);
    st_wdata = 5'h00; cyc(); st_wr = 0; st_wdata = 5'h1f;
    chk("R2", "disarmed", st_rdata[0], 1);
    sw_clear(5'b00001);
    chk("R3", "tx_empty sw clr", st_rdata[0], 0);
    chk("R8", "tx_done with tdre", st_rdata[5], 0);

    tie = 1; cyc();
    chk("R12", "tx_irq off", txi, 0);
    xfer = 1; cyc(); xfer = 0;
    chk("R3", "xfer sets", st_rdata[0], 1);
    chk("R12", "tx_irq on", txi, 1);
    chk("R8", "tx_done stays", st_rdata[5], 0);

    gsm = 0; blk = 0;
    char_end = 1; cyc(); char_end = 0;
    tick_n(4);
    chk("R10", "std 4 ticks", st_rdata[5], 0);
    tick_n(1);
    chk("R10", "std 5 ticks", st_rdata[5], 1);

    st_rd = 1; cyc(); st_rd = 0;
    st_wr = 1; st_wdata = 5'h1f; cyc(); st_wr = 0;
    chk("R8", "tx_done read-only", st_rdata[5], 1);

    rie = 1;
    rx_data = 8'h03; rx_par = 0; odd = 0; rx_done = 1; cyc(); rx_done = 0;
    chk("R4", "rx_full", st_rdata[1], 1);
    chk("R6", "par ok even", st_rdata[4], 0);
    chk("R12", "rx_irq", rxi, 1);
    rx_done = 1; cyc(); rx_done = 0;
    chk("R5", "overrun", st_rdata[2], 1);
    chk("R5", "rx_full kept", st_rdata[1], 1);
    chk("R12", "err_irq", eri, 1);
    dma_rd = 1; cyc(); dma_rd = 0;
    chk("R4", "dma read clr", st_rdata[1], 0);

    rx_data = 8'h03; rx_par = 1; odd = 1; rx_done = 1; cyc(); rx_done = 0;
    chk("R6", "par ok odd", st_rdata[4], 0);
    chk("R4", "rx_full odd", st_rdata[1], 1);
    dma_rd = 1; cyc(); dma_rd = 0;
    rx_data = 8'h01; rx_par = 0; odd = 0; rx_done = 1; cyc(); rx_done = 0;
    chk("R6", "par bad", st_rdata[4], 1);
    chk("R6", "rx_full not set", st_rdata[1], 0);

    err_low = 1; cyc(); err_low = 0;
    chk("R7", "err_sig set", st_rdata[3], 1);
    tx_en = 0; cyc();
    chk("R7", "tx_en off keeps err", st_rdata[3], 1);
    tx_en = 1; cyc();

    st_rd = 1; cyc(); st_rd = 0;
    st_wr = 1; st_wdata = 5'h00; err_low = 1; cyc(); st_wr = 0; err_low = 0; st_wdata = 5'h1f;
    chk("R11", "err set beats clr", st_rdata[3], 1);
    chk("R2", "overrun cleared", st_rdata[2], 0);
    chk("R2", "par_err cleared", st_rdata[4], 0);

    standby = 1; cyc(); standby = 0;
    chk("R13", "standby err", st_rdata[3], 0);
    chk("R13", "standby tend", st_rdata[5], 1);

    xfer = 1; cyc(); xfer = 0;
    sw_clear(5'b00001);
    chk("R8", "tend cleared", st_rdata[5], 0);
    tx_en = 0; cyc();
    chk("R9", "tx off sets tend", st_rdata[5], 1);
    tx_en = 1; cyc();

    sw_clear(5'b00001);
    xfer = 1; cyc(); xfer = 0;
    gsm = 1;
    char_end = 1; cyc(); char_end = 0;
    tick_n(1);
    err_low = 1; cyc(); err_low = 0;
    tick_n(2);
    chk("R10", "cancelled wait", st_rdata[5], 0);

    standby = 1; cyc(); standby = 0;
    sw_clear(5'b00001);
    xfer = 1; cyc(); xfer = 0;
    gsm = 0; blk = 1;
    char_end = 1; cyc(); char_end = 0;
    tick_n(2);
    chk("R10", "blk 2 ticks", st_rdata[5], 0);
    tick_n(1);
    chk("R10", "blk 3 ticks", st_rdata[5], 1);

    st_rd = 1; cyc(); st_rd = 0;
    st_wr = 1; st_wdata = 5'h1e; xfer = 1; cyc(); st_wr = 0; xfer = 0; st_wdata = 5'h1f;
    chk("R11", "xfer beats clr", st_rdata[0], 1);

    for (int m = 0; m < 4; m++) begin
      gsm = m[1]; blk = m[0];
      for (int c = 0; c < 2500; c++) begin
        tx_en    = ($urandom % 40) != 0;
        xfer     = ($urandom % 10) == 0;
        char_end = ($urandom % 30) == 0;
        htick    = ($urandom % 3) == 0;
        rx_done  = ($urandom % 15) == 0;
        rx_data  = 8'($urandom);
        rx_par   = 1'($urandom);
        odd      = 1'($urandom);
        err_low  = ($urandom % 60) == 0;
        standby  = ($urandom % 200) == 0;
        dma_wr   = ($urandom % 20) == 0;
        dma_rd   = ($urandom % 12) == 0;
        st_rd    = ($urandom % 4) == 0;
        st_wr    = ($urandom % 6) == 0;
        st_wdata = 5'($urandom);
        if (($urandom % 50) == 0) tie = ~tie;
        if (($urandom % 50) == 0) rie = ~rie;
        cyc();
      end
    end
    {tx_en, xfer, char_end, htick, rx_done, err_low, standby, dma_wr, dma_rd, st_rd, st_wr} = '0;
    cyc(); cyc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule